// File: doc/BRIEF.md
# Clock Output Gating and Strap Latch

This block sits behind the clock dividers of a system clock generator and decides, for every output, whether each source clock reaches its pin. It serves a processor group, a group of stoppable bus clocks plus one free-running bus clock, a graphics-port group, an interrupt-controller group, a fixed 48 MHz output and a peripheral output that carries either the 24 MHz or the 48 MHz source. Each output has its own enable bit from the configuration registers. Two active-low stop pins halt the processor and bus groups. An active-low power-down pin silences everything.

All gating is glitch-free. A request is synchronised into the output's own clock domain by two rising-edge flops. It is then captured on the falling edge, so an output only ever starts or stops at a low phase. Disabled outputs sit at a solid low. The peripheral output uses a two-leg switch: a leg is switched on only after the other leg has turned off.

After reset is released, the block waits a fixed number of reference-clock cycles. It then samples the five frequency-select strap lines once and holds that code until the next reset. No data stream passes through the block. All inputs are plain level controls, so there is no valid/ready handshake and no back-pressure.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low, every processor output is low. The request seen at a source rising edge k governs the high phase that starts at rising edge k+2.
- R2: While `pci_stop_n` is low, every stoppable bus output is low. The free-running bus output ignores `pci_stop_n` and keeps toggling whenever its enable bit is 1 and power-down is inactive.
- R3: While `pwrdn_n` is low, every output is low, including the free-running bus output and the peripheral output.
- R4: An output whose enable bit is 0 stays low (bit i of each enable vector controls output i of that group).
- R5: An output changes state only at the boundary of a full source pulse. It is low throughout every low phase of its source, and a request change first shows two rising edges after it is sampled.
- R6: `fs_code` is 0 until the STRAP_DLY-th `ref_clk` rising edge after reset release. At that edge it takes `fs_pins`, with bit i of the code equal to bit i of the pins.
- R7: After that capture, `fs_code` does not change while `rst_n` stays high, whatever `fs_pins` does.
- R8: `sio_sel48` = 1 routes the 48 MHz source to `sio_clk_o`, and 0 (the reset value of the register bit) routes the 24 MHz source. After the select, `sio_en` or `pwrdn_n` change, the output settles within 12 cycles of the 48 MHz source. While it settles it only ever shows low or one of the two sources, and both legs are never on at once.
- R9: While `rst_n` is low, all clock outputs and `fs_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_src | input | 1 | Divided processor source clock |
| pci_src | input | 1 | Divided bus source clock |
| agp_src | input | 1 | Divided graphics-port source clock |
| apic_src | input | 1 | Interrupt-controller source clock |
| clk48_src | input | 1 | 48 MHz source clock |
| clk24_src | input | 1 | 24 MHz source clock |
| ref_clk | input | 1 | Reference clock for the strap latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_pins | input | 5 | Frequency-select strap lines |
| cpu_stop_n | input | 1 | Active-low processor group stop |
| pci_stop_n | input | 1 | Active-low stoppable bus group stop |
| pwrdn_n | input | 1 | Active-low power-down |
| cpu_en | input | N_CPU | Per-output processor enables |
| pci_en | input | N_PCI | Per-output stoppable bus enables |
| pcif_en | input | 1 | Free-running bus output enable |
| agp_en | input | N_AGP | Per-output graphics-port enables |
| apic_en | input | N_APIC | Per-output interrupt-controller enables |
| usb_en | input | 1 | Fixed 48 MHz output enable |
| sio_en | input | 1 | Peripheral output enable |
| sio_sel48 | input | 1 | Peripheral frequency select, 1 = 48 MHz |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated stoppable bus clocks |
| pcif_clk_o | output | 1 | Free-running bus clock |
| agp_clk_o | output | N_AGP | Gated graphics-port clocks |
| apic_clk_o | output | N_APIC | Gated interrupt-controller clocks |
| usb_clk_o | output | 1 | Gated 48 MHz clock |
| sio_clk_o | output | 1 | Gated 24/48 MHz peripheral clock |
| fs_code | output | 5 | Latched frequency-select code |

## Verification
Group outputs follow the request that was sampled two source rising edges earlier. The reference model therefore keeps a two-deep queue of requests and compares every high phase against the entry at its head. Every low phase is checked to be solid low. The strap code is due exactly at the STRAP_DLY-th reference edge, and the model counts edges from reset release to predict it. The peripheral switch crosses two clock domains, so its exact value is only demanded once its controls have been quiet for 12 cycles. Before that, each sample must be low or equal to one of the two sources.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int FS_W       = 5;
  localparam int SYNC_DEPTH = 2;
  typedef logic [FS_W-1:0] fs_code_t;
endpackage

// File: rtl/clk_en_sync.sv
`timescale 1ns/1ps
// Brings a level request into one clock domain and re-times it on the
// falling edge, so the resulting enable only moves while the clock is low.
module clk_en_sync #(
  parameter int SYNC_DEPTH = clkout_pkg::SYNC_DEPTH
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic req,
  output logic en
);
  logic [SYNC_DEPTH-1:0] sync_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], req};
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= sync_q[SYNC_DEPTH-1];
  end
endmodule

// File: rtl/clk_group.sv
`timescale 1ns/1ps
// A set of outputs that share one source clock, each with its own request.
module clk_group #(
  parameter int N          = 3,
  parameter int SYNC_DEPTH = clkout_pkg::SYNC_DEPTH
) (
  input  logic         clk_src,
  input  logic         rst_n,
  input  logic [N-1:0] run_req,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] en;

  for (genvar i = 0; i < N; i++) begin : g_cell
    clk_en_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .req     (run_req[i]),
      .en      (en[i])
    );
    assign clk_out[i] = clk_src & en[i];
  end
endmodule

// File: rtl/clk_sel_mux.sv
`timescale 1ns/1ps
// Two-leg break-before-make clock switch. A leg may only turn on once the
// other leg's enable, seen through its synchroniser, has gone low.
module clk_sel_mux #(
  parameter int SYNC_DEPTH = clkout_pkg::SYNC_DEPTH
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pick_a,
  output logic [1:0] leg_on
);
  logic req_a, req_b;

  assign req_a = run &  pick_a & ~leg_on[1];
  assign req_b = run & ~pick_a & ~leg_on[0];

  clk_en_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_leg_a (
    .clk_src (clk_a),
    .rst_n   (rst_n),
    .req     (req_a),
    .en      (leg_on[0])
  );

  clk_en_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_leg_b (
    .clk_src (clk_b),
    .rst_n   (rst_n),
    .req     (req_b),
    .en      (leg_on[1])
  );
endmodule

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
// Samples the strap lines once, STRAP_DLY reference edges after reset.
module strap_latch #(
  parameter int FS_W      = clkout_pkg::FS_W,
  parameter int STRAP_DLY = 8
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_pins,
  output logic [FS_W-1:0] fs_code
);
  localparam int CW = (STRAP_DLY > 1) ? $clog2(STRAP_DLY) : 1;

  logic [CW-1:0] cnt_q;
  logic          taken_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      taken_q <= 1'b0;
      fs_code <= '0;
    end else if (!taken_q) begin
      if (cnt_q == CW'(STRAP_DLY - 1)) begin
        fs_code <= fs_pins;
        taken_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl #(
  parameter int N_CPU      = 3,
  parameter int N_PCI      = 8,
  parameter int N_AGP      = 3,
  parameter int N_APIC     = 3,
  parameter int STRAP_DLY  = 8,
  parameter int SYNC_DEPTH = clkout_pkg::SYNC_DEPTH
) (
  input  logic                       cpu_src,
  input  logic                       pci_src,
  input  logic                       agp_src,
  input  logic                       apic_src,
  input  logic                       clk48_src,
  input  logic                       clk24_src,
  input  logic                       ref_clk,
  input  logic                       rst_n,
  input  logic [clkout_pkg::FS_W-1:0] fs_pins,
  input  logic                       cpu_stop_n,
  input  logic                       pci_stop_n,
  input  logic                       pwrdn_n,
  input  logic [N_CPU-1:0]           cpu_en,
  input  logic [N_PCI-1:0]           pci_en,
  input  logic                       pcif_en,
  input  logic [N_AGP-1:0]           agp_en,
  input  logic [N_APIC-1:0]          apic_en,
  input  logic                       usb_en,
  input  logic                       sio_en,
  input  logic                       sio_sel48,
  output logic [N_CPU-1:0]           cpu_clk_o,
  output logic [N_PCI-1:0]           pci_clk_o,
  output logic                       pcif_clk_o,
  output logic [N_AGP-1:0]           agp_clk_o,
  output logic [N_APIC-1:0]          apic_clk_o,
  output logic                       usb_clk_o,
  output logic                       sio_clk_o,
  output logic [clkout_pkg::FS_W-1:0] fs_code
);
  localparam int N_BUS = N_PCI + 1;   // stoppable outputs plus the free-running one

  logic [N_CPU-1:0]  cpu_req;
  logic [N_BUS-1:0]  bus_req;
  logic [N_BUS-1:0]  bus_clk;
  logic [N_AGP-1:0]  agp_req;
  logic [N_APIC-1:0] apic_req;
  logic [0:0]        usb_req;
  logic [0:0]        usb_clk;
  logic [1:0]        sio_leg;

  assign cpu_req  = cpu_en  & {N_CPU{cpu_stop_n & pwrdn_n}};
  assign bus_req  = {pcif_en & pwrdn_n, pci_en & {N_PCI{pci_stop_n & pwrdn_n}}};
  assign agp_req  = agp_en  & {N_AGP{pwrdn_n}};
  assign apic_req = apic_en & {N_APIC{pwrdn_n}};
  assign usb_req  = usb_en  & pwrdn_n;

  clk_group #(.N(N_CPU), .SYNC_DEPTH(SYNC_DEPTH)) u_cpu (
    .clk_src(cpu_src), .rst_n(rst_n), .run_req(cpu_req), .clk_out(cpu_clk_o));

  clk_group #(.N(N_BUS), .SYNC_DEPTH(SYNC_DEPTH)) u_bus (
    .clk_src(pci_src), .rst_n(rst_n), .run_req(bus_req), .clk_out(bus_clk));

  clk_group #(.N(N_AGP), .SYNC_DEPTH(SYNC_DEPTH)) u_agp (
    .clk_src(agp_src), .rst_n(rst_n), .run_req(agp_req), .clk_out(agp_clk_o));

  clk_group #(.N(N_APIC), .SYNC_DEPTH(SYNC_DEPTH)) u_apic (
    .clk_src(apic_src), .rst_n(rst_n), .run_req(apic_req), .clk_out(apic_clk_o));

  clk_group #(.N(1), .SYNC_DEPTH(SYNC_DEPTH)) u_usb (
    .clk_src(clk48_src), .rst_n(rst_n), .run_req(usb_req), .clk_out(usb_clk));

  assign pci_clk_o  = bus_clk[N_PCI-1:0];
  assign pcif_clk_o = bus_clk[N_PCI];
  assign usb_clk_o  = usb_clk[0];

  clk_sel_mux #(.SYNC_DEPTH(SYNC_DEPTH)) u_sio (
    .clk_a  (clk48_src),
    .clk_b  (clk24_src),
    .rst_n  (rst_n),
    .run    (sio_en & pwrdn_n),
    .pick_a (sio_sel48),
    .leg_on (sio_leg)
  );

  assign sio_clk_o = (clk48_src & sio_leg[0]) | (clk24_src & sio_leg[1]);

  strap_latch #(.FS_W(clkout_pkg::FS_W), .STRAP_DLY(STRAP_DLY)) u_strap (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .fs_pins (fs_pins),
    .fs_code (fs_code)
  );
endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_chk #(
  parameter int N_CPU     = 3,
  parameter int N_PCI     = 8,
  parameter int N_AGP     = 3,
  parameter int STRAP_DLY = 8
) (
  input logic                        cpu_src,
  input logic                        pci_src,
  input logic                        agp_src,
  input logic                        clk48_src,
  input logic                        ref_clk,
  input logic                        rst_n,
  input logic                        cpu_stop_n,
  input logic                        pci_stop_n,
  input logic                        pwrdn_n,
  input logic                        pcif_en,
  input logic [N_AGP-1:0]            agp_en,
  input logic [N_CPU-1:0]            cpu_clk_o,
  input logic [N_PCI-1:0]            pci_clk_o,
  input logic                        pcif_clk_o,
  input logic [N_AGP-1:0]            agp_clk_o,
  input logic                        usb_clk_o,
  input logic [clkout_pkg::FS_W-1:0] fs_code,
  input logic [1:0]                  sio_leg
);
  int unsigned ref_cnt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                      ref_cnt_q <= 0;
    else if (ref_cnt_q <= STRAP_DLY) ref_cnt_q <= ref_cnt_q + 1;
  end

  AST_CPU_HALT: assert property (@(negedge cpu_src) disable iff (!rst_n)
    (!cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 3))
      |-> (cpu_clk_o == '0)) else $error("cpu outputs run while stopped"); // R1

  AST_PCI_HALT: assert property (@(negedge pci_src) disable iff (!rst_n)
    (!pci_stop_n && !$past(pci_stop_n) && !$past(pci_stop_n, 2) && !$past(pci_stop_n, 3))
      |-> (pci_clk_o == '0)) else $error("bus outputs run while stopped"); // R2

  AST_PCIF_FREE: assert property (@(negedge pci_src) disable iff (!rst_n)
    (pcif_en && $past(pcif_en) && $past(pcif_en, 2) && $past(pcif_en, 3) &&
     pwrdn_n && $past(pwrdn_n) && $past(pwrdn_n, 2) && $past(pwrdn_n, 3) && $past(rst_n, 3))
      |-> pcif_clk_o) else $error("free-running bus output halted"); // R2

  AST_PD_BUS_LOW: assert property (@(negedge pci_src) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
      |-> (!pcif_clk_o && pci_clk_o == '0)) else $error("bus output alive in power-down"); // R3

  AST_PD_USB_LOW: assert property (@(negedge clk48_src) disable iff (!rst_n)
    (!pwrdn_n && !$past(pwrdn_n) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3))
      |-> !usb_clk_o) else $error("48 MHz output alive in power-down"); // R3

  AST_AGP_OFF: assert property (@(negedge agp_src) disable iff (!rst_n)
    ((agp_clk_o & ~agp_en & ~$past(agp_en) & ~$past(agp_en, 2) & ~$past(agp_en, 3)) == '0))
    else $error("disabled graphics output toggles"); // R4

  AST_FS_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_cnt_q < STRAP_DLY) |-> (fs_code == '0)) else $error("strap code early"); // R6

  AST_FS_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_cnt_q > STRAP_DLY) |-> $stable(fs_code)) else $error("strap code moved"); // R7

  AST_SIO_EXCL: assert property (@(posedge clk48_src) disable iff (!rst_n)
    $onehot0(sio_leg)) else $error("both peripheral legs on"); // R8
endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .STRAP_DLY(STRAP_DLY)
) u_chk (
  .cpu_src    (cpu_src),
  .pci_src    (pci_src),
  .agp_src    (agp_src),
  .clk48_src  (clk48_src),
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .cpu_stop_n (cpu_stop_n),
  .pci_stop_n (pci_stop_n),
  .pwrdn_n    (pwrdn_n),
  .pcif_en    (pcif_en),
  .agp_en     (agp_en),
  .cpu_clk_o  (cpu_clk_o),
  .pci_clk_o  (pci_clk_o),
  .pcif_clk_o (pcif_clk_o),
  .agp_clk_o  (agp_clk_o),
  .usb_clk_o  (usb_clk_o),
  .fs_code    (fs_code),
  .sio_leg    (sio_leg)
);

// File: tb/clkout_gate_ctrl_test.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_test;
  localparam int NC  = 3;
  localparam int NP  = 8;
  localparam int NG  = 3;
  localparam int NA  = 3;
  localparam int DLY = 8;
  localparam int NV  = NC + NP + 1 + NG + NA + 1;
  localparam int B_PCI  = NC;
  localparam int B_PCIF = NC + NP;
  localparam int B_AGP  = NC + NP + 1;
  localparam int B_APIC = B_AGP + NG;
  localparam int B_USB  = NV - 1;
  localparam int SETTLE = 12;

  logic clk = 1'b0, clk24 = 1'b0, rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
  logic sio_en = 1'b1, sel48 = 1'b0;
  logic [NV-1:0] en_v = '1;
  logic [4:0] fs_pins = 5'b10110;

  logic [NC-1:0] cpu_o;
  logic [NP-1:0] pci_o;
  logic          pcif_o;
  logic [NG-1:0] agp_o;
  logic [NA-1:0] apic_o;
  logic          usb_o, sio_o;
  logic [4:0]    fs_code;

  int n_chk = 0, n_fail = 0;

  clkout_gate_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_AGP(NG), .N_APIC(NA), .STRAP_DLY(DLY)) uut (
    .cpu_src(clk), .pci_src(clk), .agp_src(clk), .apic_src(clk),
    .clk48_src(clk), .clk24_src(clk24), .ref_clk(clk), .rst_n(rst_n),
    .fs_pins(fs_pins), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
    .cpu_en(en_v[NC-1:0]), .pci_en(en_v[B_PCIF-1:B_PCI]), .pcif_en(en_v[B_PCIF]),
    .agp_en(en_v[B_APIC-1:B_AGP]), .apic_en(en_v[B_USB-1:B_APIC]), .usb_en(en_v[B_USB]),
    .sio_en(sio_en), .sio_sel48(sel48),
    .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pcif_clk_o(pcif_o), .agp_clk_o(agp_o),
    .apic_clk_o(apic_o), .usb_clk_o(usb_o), .sio_clk_o(sio_o), .fs_code(fs_code));

  // 250 MHz base clock; the 24 MHz stand-in runs at half rate, edges aligned.
  initial forever begin
    #2 clk = ~clk;
    if (clk) clk24 = ~clk24;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [NV-1:0] req_now();
    logic [NV-1:0] r = en_v;
    if (!cpu_stop_n) r[NC-1:0] = '0;
    if (!pci_stop_n) r[B_PCIF-1:B_PCI] = '0;
    if (!pwrdn_n)    r = '0;
    return r;
  endfunction

  // Reference model state
  logic [NV-1:0] hist[$];
  logic [NV-1:0] exp_g, got_g;
  int            pcount = 0, sio_quiet = 0;
  logic [4:0]    strap_exp = '0;
  logic          p_sel = 1'b0, p_en = 1'b1, p_pd = 1'b1;

  assign got_g = {usb_o, apic_o, agp_o, pcif_o, pci_o, cpu_o};

  task automatic check_sio();
    logic run, src;
    run = p_en & p_pd & rst_n;
    src = p_sel ? clk : clk24;
    if (sio_quiet >= SETTLE)
      chk(p_pd ? "R8 peripheral select" : "R3 peripheral power-down", 32'(sio_o), 32'(run & src));
    else
      chk("R8 peripheral switch membership",
          32'(sio_o == 1'b0 || sio_o == clk || sio_o == clk24), 32'd1);
  endtask

  initial begin
    hist = {NV'(0), NV'(0)};
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        hist = {NV'(0), NV'(0)};
        exp_g = '0;
        pcount = 0;
      end else begin
        exp_g = hist.pop_front();
        hist.push_back(req_now());
        pcount++;
        if (pcount == DLY) strap_exp = fs_pins;
      end
      if (!rst_n || {sel48, sio_en, pwrdn_n} != {p_sel, p_en, p_pd}) sio_quiet = 0;
      else sio_quiet++;
      p_sel = sel48; p_en = sio_en; p_pd = pwrdn_n;
      #1;
      if (!rst_n) begin
        chk("R9 reset outputs", 32'(got_g), 32'd0);
        chk("R9 reset strap code", 32'(fs_code), 32'd0);
      end else begin
        if (exp_g == '0 && !p_pd)
          chk("R3 power-down all low", 32'(got_g), 32'd0);
        else begin
          chk("R1 cpu group", 32'(got_g[NC-1:0]), 32'(exp_g[NC-1:0]));
          chk("R2 bus group", 32'(got_g[B_PCIF:B_PCI]), 32'(exp_g[B_PCIF:B_PCI]));
          chk("R4 enables agp/apic/usb", 32'(got_g[NV-1:B_AGP]), 32'(exp_g[NV-1:B_AGP]));
        end
        if (pcount > DLY)
          chk("R7 strap code held", 32'(fs_code), 32'(strap_exp));
        else
          chk("R6 strap capture", 32'(fs_code), pcount >= DLY ? 32'(strap_exp) : 32'd0);
      end
      check_sio();
      @(negedge clk);
      #1;
      chk("R5 low phase solid", 32'(got_g), 32'd0);
      check_sio();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;                         // R9 checked during reset, R6 on release
    wait_cyc(20);
    fs_pins = 5'b01001;                   // R7: straps move after capture
    wait_cyc(6);
    cpu_stop_n = 1'b0; wait_cyc(10);      // R1
    cpu_stop_n = 1'b1; wait_cyc(8);
    pci_stop_n = 1'b0; wait_cyc(10);      // R2, free-running output still runs
    en_v[B_PCIF] = 1'b0; wait_cyc(6);
    en_v[B_PCIF] = 1'b1; pci_stop_n = 1'b1; wait_cyc(8);
    for (int i = 0; i < 16; i++) begin    // R5: rapid stop changes
      cpu_stop_n = i[0];
      pci_stop_n = i[1];
      wait_cyc(1);
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; wait_cyc(4);
    en_v = NV'(19'h2AAAA); wait_cyc(6);   // R4 patterns
    en_v = NV'(19'h55555); wait_cyc(6);
    en_v = '0;             wait_cyc(6);
    for (int i = 0; i < 6; i++) begin
      en_v = NV'($urandom);
      wait_cyc(5);
    end
    en_v = '1; wait_cyc(4);
    sel48 = 1'b1; wait_cyc(30);           // R8
    sel48 = 1'b0; wait_cyc(30);
    sio_en = 1'b0; wait_cyc(20);
    sio_en = 1'b1; sel48 = 1'b1; wait_cyc(20);
    pwrdn_n = 1'b0; wait_cyc(20);         // R3
    pwrdn_n = 1'b1; wait_cyc(20);
    rst_n = 1'b0; fs_pins = 5'b11100;     // re-latch after a new reset
    wait_cyc(3);
    rst_n = 1'b1; wait_cyc(20);
    fs_pins = 5'b00011; wait_cyc(10);
    summary();
    $finish;
  end
endmodule